// File: doc/BRIEF.md
# Conditional skip evaluator

This block executes the second group of operate instructions of a 12-bit accumulator machine. It takes one instruction word together with the current accumulator (AC), the link bit and a 12-bit switch register value. For each instruction it produces three results: whether the next instruction is to be skipped, the new AC value, and a halt request. The program-counter logic around the block advances by one extra word whenever the skip flag is high.

The skip test picks up to three conditions on AC and the link. A sense bit decides how they combine. With the sense bit clear, the block skips if any selected condition is true. With the sense bit set, the block skips only if none of them is true, which by De Morgan is an AND of the opposite tests. The same instruction can also clear AC, OR the switch register into AC, and request a halt.

Operate instructions of the third group, which work on a multiplier-quotient register, are not executed here. They raise a separate flag so that another unit can take them. Any other instruction leaves AC unchanged and produces no skip and no halt. With the default configuration all results are registered and appear one cycle after the strobe.

Top module: `skip_eval`

## Requirements
- R1: An instruction is executed here only when `in_valid` is 1, bits [11:9] are 3'b111, bit 8 is 1 and bit 0 is 0. Any other valid word gives `skip`=0, `halt`=0 and `ac_out`=`ac_in`.
- R2: `grp3_flag` is 1 for a valid word with bits [11:9]=3'b111, bit 8=1 and bit 0=1, and is 0 for every other word.
- R3: With bit 3 (the sense bit) at 0, `skip` is the OR of the selected tests. The tests are: bit 6 selects "AC bit 11 is 1", bit 5 selects "AC is zero", and bit 4 selects "link is 1". For example, word 7540 octal skips when AC is 0 or negative.
- R4: With bit 3 at 1, `skip` is 1 only when none of the selected tests of R3 holds. For example, 7550 octal skips when AC is strictly positive, and 7430 octal skips when the link is 0.
- R5: With bits 6..4 all 0, `skip` equals bit 3. So 7410 octal always skips and 7400 octal never skips.
- R6: The skip tests use `ac_in` as presented, even when the same word clears AC or ORs in the switches.
- R7: When bit 7 is 1, AC is cleared. When both bit 7 and bit 2 are 0, `ac_out` equals `ac_in`.
- R8: When bit 2 is 1, `sw_in` is ORed into AC after any clear. So bit 7 together with bit 2 loads `sw_in` into AC.
- R9: Bit 1 makes `halt` 1 in the same cycle as the other results of that instruction. `halt` is 0 in the cycle after, unless another halting instruction arrives.
- R10: After reset, and in every cycle that follows a cycle with `in_valid`=0, `out_valid`, `skip`, `halt`, `grp3_flag` are 0 and `ac_out` is 0. With REG_OUT=1, every result appears on the first clock edge after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: instr, ac_in, link_in and sw_in are valid |
| instr | input | 12 | Instruction word |
| ac_in | input | 12 | Current accumulator |
| link_in | input | 1 | Current link bit |
| sw_in | input | 12 | Switch register value |
| out_valid | output | 1 | Results below belong to a strobed word |
| skip | output | 1 | Skip the next instruction |
| ac_out | output | 12 | New accumulator value |
| halt | output | 1 | One-cycle halt request |
| grp3_flag | output | 1 | Word belongs to the third operate group and was not executed |

## Verification
In the default configuration every result (skip, new AC, halt, group-three flag and out_valid) is due on the first rising edge after the strobed cycle. No result needs more than that one register. The bench drives each word on a falling edge, lets the next rising edge capture it, and samples all outputs on the falling edge that follows. It then drives the next word in that same half cycle, so each sample belongs to exactly one instruction. After a halting word, the bench inserts an idle cycle and samples it to confirm that the halt pulse lasted a single cycle.

// File: rtl/skip_pkg.sv
package skip_pkg;

   // Word geometry, LSB-indexed positions inside a 12-bit operate word
   localparam int unsigned OPW       = 12;
   localparam int unsigned OPC_HI    = 11;
   localparam int unsigned OPC_LO    = 9;
   localparam int unsigned GRP_HI    = 8;   // 1 for groups two and three
   localparam int unsigned GRP_LO    = 0;   // 0 for group two, 1 for group three
   localparam int unsigned B_CLR     = 7;
   localparam int unsigned B_NEG     = 6;
   localparam int unsigned B_ZER     = 5;
   localparam int unsigned B_LNK     = 4;
   localparam int unsigned B_SENSE   = 3;
   localparam int unsigned B_SWOR    = 2;
   localparam int unsigned B_HALT    = 1;

   localparam logic [2:0] OPC_OPERATE = 3'b111;

   typedef struct packed {
      logic clr;
      logic t_neg;
      logic t_zero;
      logic t_link;
      logic sense;
      logic sw_or;
      logic hlt;
   } opr2_ctl_t;

endpackage

// File: rtl/skip_decode.sv
module skip_decode
   import skip_pkg::*;
#(
   parameter int unsigned WORD_W = 12
) (
   input  logic [WORD_W-1:0] word,
   output logic              is_g2,
   output logic              is_g3,
   output opr2_ctl_t         ctl
);

   initial begin
      if (WORD_W != OPW)
         $error("skip_decode: WORD_W must be %0d", OPW);
   end

   logic opr_hit;

   always_comb begin
      opr_hit    = (word[OPC_HI:OPC_LO] == OPC_OPERATE) && word[GRP_HI];
      is_g2      = opr_hit && !word[GRP_LO];
      is_g3      = opr_hit &&  word[GRP_LO];
      ctl.clr    = word[B_CLR];
      ctl.t_neg  = word[B_NEG];
      ctl.t_zero = word[B_ZER];
      ctl.t_link = word[B_LNK];
      ctl.sense  = word[B_SENSE];
      ctl.sw_or  = word[B_SWOR];
      ctl.hlt    = word[B_HALT];
   end

endmodule

// File: rtl/skip_cond.sv
module skip_cond
   import skip_pkg::*;
#(
   parameter int unsigned DATA_W = 12
) (
   input  opr2_ctl_t         ctl,
   input  logic [DATA_W-1:0] acc,
   input  logic              lnk,
   output logic              take
);

   initial begin
      if (DATA_W < 2)
         $error("skip_cond: DATA_W must be at least 2");
   end

   logic is_neg;
   logic is_zero;
   logic any_hit;

   always_comb begin
      is_neg  = acc[DATA_W-1];
      is_zero = (acc == '0);
      any_hit = (ctl.t_neg  && is_neg)
              | (ctl.t_zero && is_zero)
              | (ctl.t_link && lnk);
      // sense bit flips the OR of tests into the AND of their complements
      take    = ctl.sense ^ any_hit;
   end

endmodule

// File: rtl/skip_acc.sv
module skip_acc
   import skip_pkg::*;
#(
   parameter int unsigned DATA_W = 12
) (
   input  opr2_ctl_t         ctl,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] sw,
   output logic [DATA_W-1:0] acc_new
);

   logic [DATA_W-1:0] after_clr;

   always_comb begin
      after_clr = ctl.clr   ? '0 : acc;
      acc_new   = ctl.sw_or ? (after_clr | sw) : after_clr;
   end

endmodule

// File: rtl/skip_eval.sv
module skip_eval
   import skip_pkg::*;
#(
   parameter int unsigned WORD_W  = 12,
   parameter int unsigned DATA_W  = 12,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] instr,
   input  logic [DATA_W-1:0] ac_in,
   input  logic              link_in,
   input  logic [DATA_W-1:0] sw_in,
   output logic              out_valid,
   output logic              skip,
   output logic [DATA_W-1:0] ac_out,
   output logic              halt,
   output logic              grp3_flag
);

   initial begin
      if (WORD_W != OPW)
         $error("skip_eval: WORD_W must be %0d", OPW);
      if (DATA_W < 2)
         $error("skip_eval: DATA_W must be at least 2");
   end

   logic              g2;
   logic              g3;
   opr2_ctl_t         ctl;
   logic              take_raw;
   logic [DATA_W-1:0] acc_raw;

   logic              nx_skip;
   logic              nx_halt;
   logic              nx_g3;
   logic [DATA_W-1:0] nx_acc;

   skip_decode #(.WORD_W(WORD_W)) u_dec (
      .word  (instr),
      .is_g2 (g2),
      .is_g3 (g3),
      .ctl   (ctl)
   );

   skip_cond #(.DATA_W(DATA_W)) u_cond (
      .ctl  (ctl),
      .acc  (ac_in),
      .lnk  (link_in),
      .take (take_raw)
   );

   skip_acc #(.DATA_W(DATA_W)) u_acc (
      .ctl     (ctl),
      .acc     (ac_in),
      .sw      (sw_in),
      .acc_new (acc_raw)
   );

   always_comb begin
      nx_skip = in_valid && g2 && take_raw;
      nx_halt = in_valid && g2 && ctl.hlt;
      nx_g3   = in_valid && g3;
      if (!in_valid)
         nx_acc = '0;
      else if (g2)
         nx_acc = acc_raw;
      else
         nx_acc = ac_in;
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               skip      <= 1'b0;
               halt      <= 1'b0;
               grp3_flag <= 1'b0;
               ac_out    <= '0;
            end else begin
               out_valid <= in_valid;
               skip      <= nx_skip;
               halt      <= nx_halt;
               grp3_flag <= nx_g3;
               ac_out    <= nx_acc;
            end
         end
      end else begin : g_comb
         always_comb begin
            out_valid = in_valid;
            skip      = nx_skip;
            halt      = nx_halt;
            grp3_flag = nx_g3;
            ac_out    = nx_acc;
         end
      end
   endgenerate

endmodule

// File: rtl/skip_eval_chk.sv
module skip_eval_chk #(
   parameter int unsigned WORD_W  = 12,
   parameter int unsigned DATA_W  = 12,
   parameter bit          REG_OUT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [WORD_W-1:0] instr,
   input logic [DATA_W-1:0] ac_in,
   input logic              link_in,
   input logic [DATA_W-1:0] sw_in,
   input logic              out_valid,
   input logic              skip,
   input logic [DATA_W-1:0] ac_out,
   input logic              halt,
   input logic              grp3_flag
);

   logic opr_top;
   logic in_g2;
   logic in_g3;
   assign opr_top = (instr[WORD_W-1:WORD_W-3] == 3'b111) && instr[8];
   assign in_g2   = in_valid && opr_top && !instr[0];
   assign in_g3   = in_valid && opr_top &&  instr[0];

   generate
      if (REG_OUT) begin : g_chk
         AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == $past(in_valid)); // R10
         AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !skip && !halt && !grp3_flag); // R10
         AST_OTHER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !in_g2) |=> !skip && !halt && ac_out == $past(ac_in)); // R1
         AST_G3_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            in_g3 |=> grp3_flag); // R2
         AST_ALWAYS_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
            (in_g2 && instr[6:3] == 4'b0001) |=> skip); // R5
         AST_NEVER_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
            (in_g2 && instr[6:3] == 4'b0000) |=> !skip); // R5
         AST_CLR_SWLOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (in_g2 && instr[7] && instr[2]) |=> ac_out == $past(sw_in)); // R8
         AST_HALT_SOLO: assert property (@(posedge clk) disable iff (!rst_n)
            (halt && !in_g2) |=> !halt); // R9
         AST_NEG_TEST: assert property (@(posedge clk) disable iff (!rst_n)
            (in_g2 && instr[6:3] == 4'b1000) |=> skip == $past(ac_in[DATA_W-1])); // R3
         AST_LINK_AND: assert property (@(posedge clk) disable iff (!rst_n)
            (in_g2 && instr[6:3] == 4'b0011) |=> skip == !$past(link_in)); // R4
      end
   endgenerate

endmodule

bind skip_eval skip_eval_chk #(
   .WORD_W  (WORD_W),
   .DATA_W  (DATA_W),
   .REG_OUT (REG_OUT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .instr     (instr),
   .ac_in     (ac_in),
   .link_in   (link_in),
   .sw_in     (sw_in),
   .out_valid (out_valid),
   .skip      (skip),
   .ac_out    (ac_out),
   .halt      (halt),
   .grp3_flag (grp3_flag)
);

// File: tb/skip_eval_bench.sv
module skip_eval_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [11:0] instr = '0;
   logic [11:0] ac_in = '0;
   logic        link_in = 1'b0;
   logic [11:0] sw_in = '0;
   logic        out_valid;
   logic        skip;
   logic [11:0] ac_out;
   logic        halt;
   logic        grp3_flag;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   skip_eval u_skip_eval (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
      .ac_in(ac_in), .link_in(link_in), .sw_in(sw_in),
      .out_valid(out_valid), .skip(skip), .ac_out(ac_out),
      .halt(halt), .grp3_flag(grp3_flag)
   );

   task automatic chk(string tag, logic [11:0] got, logic [11:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s instr=%o ac=%o l=%0b: got %o expected %o",
                  tag, instr, ac_in, link_in, got, exp);
      end
   endtask

   // Drive one word on a falling edge; results sampled one full cycle later.
   task automatic apply(logic [11:0] w, logic [11:0] a, logic l, logic [11:0] s);
      bit is_opr, g2, g3, neg, zer, hit, e_skip, e_halt;
      logic [11:0] e_ac;
      in_valid = 1'b1; instr = w; ac_in = a; link_in = l; sw_in = s;
      is_opr = (w[11:9] == 3'b111) && w[8];
      g2 = is_opr && !w[0];
      g3 = is_opr && w[0];
      neg = a[11];
      zer = (a == 12'd0);
      hit = (w[6] && neg) || (w[5] && zer) || (w[4] && l);
      e_skip = g2 && (w[3] ? !hit : hit);
      e_halt = g2 && w[1];
      e_ac = a;
      if (g2) begin
         if (w[7]) e_ac = 12'd0;
         if (w[2]) e_ac = e_ac | s;
      end
      @(negedge clk);
      chk("R10 out_valid", {11'd0, out_valid}, 12'd1);
      if (!g2)              chk("R1 skip", {11'd0, skip}, 12'd0);
      else if (w[6:4] == 0) chk("R5 skip", {11'd0, skip}, {11'd0, e_skip});
      else if (w[7] || w[2]) chk("R6 skip", {11'd0, skip}, {11'd0, e_skip});
      else if (w[3])        chk("R4 skip", {11'd0, skip}, {11'd0, e_skip});
      else                  chk("R3 skip", {11'd0, skip}, {11'd0, e_skip});
      if (!g2)       chk("R1 ac_out", ac_out, e_ac);
      else if (w[2]) chk("R8 ac_out", ac_out, e_ac);
      else           chk("R7 ac_out", ac_out, e_ac);
      chk("R9 halt", {11'd0, halt}, {11'd0, e_halt});
      chk("R2 grp3_flag", {11'd0, grp3_flag}, {11'd0, g3});
   endtask

   task automatic idle_check();
      in_valid = 1'b0;
      @(negedge clk);
      chk("R10 idle out_valid", {11'd0, out_valid}, 12'd0);
      chk("R9 halt after pulse", {11'd0, halt}, 12'd0);
      chk("R10 idle skip", {11'd0, skip}, 12'd0);
   endtask

   initial begin
      logic [11:0] acs [6];
      acs[0] = 12'o0000; acs[1] = 12'o0001; acs[2] = 12'o3777;
      acs[3] = 12'o4000; acs[4] = 12'o7777; acs[5] = 12'o2525;
      repeat (3) @(negedge clk);
      chk("R10 reset out_valid", {11'd0, out_valid}, 12'd0);
      chk("R10 reset skip", {11'd0, skip}, 12'd0);
      chk("R10 reset halt", {11'd0, halt}, 12'd0);
      chk("R10 reset grp3", {11'd0, grp3_flag}, 12'd0);
      chk("R10 reset ac", ac_out, 12'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // Every group-two word over a spread of AC, link and switch values
      for (int b = 0; b < 128; b++) begin
         for (int ai = 0; ai < 6; ai++) begin
            for (int l = 0; l < 2; l++) begin
               apply({4'b1111, b[6:0], 1'b0}, acs[ai], l[0],
                     (ai[0] ? 12'o1234 : 12'o6060));
            end
         end
      end

      // Worked examples named in the requirements
      apply(12'o7540, 12'o0000, 1'b0, 12'o0); // R3 AC zero skips
      apply(12'o7540, 12'o0005, 1'b1, 12'o0); // R3 positive no skip
      apply(12'o7550, 12'o0005, 1'b0, 12'o0); // R4 positive skips
      apply(12'o7550, 12'o4000, 1'b0, 12'o0); // R4 negative no skip
      apply(12'o7430, 12'o0000, 1'b0, 12'o0); // R4 link 0 skips
      apply(12'o7410, 12'o4000, 1'b1, 12'o0); // R5 always
      apply(12'o7400, 12'o0000, 1'b1, 12'o0); // R5 never
      apply(12'o7604, 12'o7777, 1'b0, 12'o0421); // R8 load switches

      // Halt pulse then idle
      apply(12'o7402, 12'o0017, 1'b0, 12'o0);
      idle_check();

      // Words outside group two, including group three
      for (int op = 0; op < 8; op++) begin
         for (int lo = 0; lo < 16; lo++) begin
            logic [11:0] w;
            w = {op[2:0], lo[3], 4'b1110, lo[2:0], lo[0]};
            if (!(op == 7 && lo[3] && !lo[0]))
               apply(w, 12'o4001, lo[1], 12'o7777);
         end
      end
      apply(12'o7621, 12'o0123, 1'b0, 12'o0); // R2 group three
      idle_check();
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: got timeout expected completion");
      end
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule